// File: doc/BRIEF.md
# Indexed Attribute Register Port

This block holds the byte-wide attribute registers of a display controller: sixteen palette entries and five control registers. All writes arrive through one I/O port. Its meaning alternates between "index" and "data" under a hidden phase flip-flop. The first write selects a register and the second write stores into it. A dedicated clear strobe returns the flip-flop to the index phase. This is how software resynchronises before a write pair.

A mode input chooses between two personalities. In legacy mode, the companion address (main address plus one) is a full alias of the main port for writes, in either phase. Several fields are narrower or wider in this mode, and nothing can be read back. In extended mode, the companion address is a read-only window on the indexed register. A read of the main address returns the current index together with the phase bit. A 16-bit write from the host arrives as two byte writes in consecutive cycles, and the block needs no special path for it. The stored values drive parallel outputs for the display pipeline.

The phase flip-flop is a two-state machine. `PH_INDEX` waits for an index byte. The transition TAKE_INDEX goes to `PH_DATA` on a port write. In `PH_DATA`, the transition COMMIT_DATA stores the byte and returns to `PH_INDEX`. The transition FORCE_INDEX goes from either state to `PH_INDEX` on the clear strobe.

Top module: `attr_port_top`

## Requirements
- R1: After reset, the phase is index, the index is 0, every register and `rdata` are 0.
- R2: A port write in the index phase stores `wdata[4:0]` as the index, moves to the data phase and changes no register. A port write in the data phase stores `wdata` (masked as in R8) into the indexed register and returns to the index phase. Register map: 0x00-0x0F palette, 0x10 mode control, 0x11 overscan, 0x12 plane enable, 0x13 pixel pan, 0x14 colour select.
- R3: With `legacy_mode`=1, a write with `addr_lo`=1 acts exactly as a write with `addr_lo`=0, in both phases.
- R4: With `legacy_mode`=0, a write with `addr_lo`=1 changes nothing. A read with `addr_lo`=1 loads `rdata`, at the next clock edge, with the indexed register.
- R5: With `legacy_mode`=0, a read with `addr_lo`=0 loads `rdata` with {phase, 2'b00, index[4:0]}, where the phase bit (bit 7) is 1 in the data phase. With `legacy_mode`=1, every read loads 0.
- R6: `ff_clear` forces the index phase at the next edge. A port write in the same cycle is discarded.
- R7: Port writes in back-to-back cycles (a split 16-bit write) behave as two separate byte writes.
- R8: Stored widths: palette 6 bits, pixel pan 4, colour select 4. Overscan is 6 bits in legacy mode and 8 in extended mode. Plane enable is 6 bits in legacy mode and 4 in extended mode. Mode control is 5 bits in legacy mode (bits 7:5 zero) and 8 in extended mode. Masked bits store as 0.
- R9: A data-phase write to an undefined index (0x15-0x1F, and 0x14 in legacy mode) changes no register but still returns to the index phase. A read of an undefined index returns 0.
- R10: Reads change neither the phase nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | 1 = legacy personality, 0 = extended |
| addr_lo | input | 1 | 0 = main port, 1 = companion address |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wdata | input | 8 | Write data |
| ff_clear | input | 1 | Forces the phase flip-flop to index |
| rdata | output | 8 | Registered read data |
| palette_flat | output | 128 | Palette entries, entry i at bits [8i+7:8i] |
| mode_ctrl | output | 8 | Mode control register |
| overscan | output | 8 | Overscan colour register |
| plane_enable | output | 8 | Colour plane enable register |
| pixel_pan | output | 8 | Pixel panning register |
| color_sel | output | 8 | Colour select register |

## Verification
The assertions take the strobes as single-cycle, synchronous inputs that are held stable across each rising edge. They treat a clear and a write in the same cycle as legal: the clear wins. They make no assumption about `legacy_mode` changing between the two halves of a pair. Field masking depends only on the mode at the data write. The stimulus changes every input only on the falling clock edge. It exercises each mode with both address aliases, clears that collide with writes, and undefined indices. A pseudo-random stretch mixes all inputs, mode changes included.

// File: rtl/attr_pkg.sv
package attr_pkg;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_IDX_W  = 5;
    localparam int DEF_PAL_N  = 16;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;
endpackage

// File: rtl/attr_phase_fsm.sv
module attr_phase_fsm
    import attr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   port_wr,
    input  logic   ff_clear,
    output phase_t phase,
    output logic   idx_load,
    output logic   data_load
);
    phase_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_INDEX;
        else        phase <= nxt;
    end

    // next state: FORCE_INDEX beats TAKE_INDEX / COMMIT_DATA
    always_comb begin
        nxt = phase;
        if (ff_clear) begin
            nxt = PH_INDEX;
        end else if (port_wr) begin
            unique case (phase)
                PH_INDEX: nxt = PH_DATA;
                PH_DATA:  nxt = PH_INDEX;
            endcase
        end
    end

    // outputs
    always_comb begin
        idx_load  = 1'b0;
        data_load = 1'b0;
        if (!ff_clear && port_wr) begin
            unique case (phase)
                PH_INDEX: idx_load  = 1'b1;
                PH_DATA:  data_load = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/attr_reg_file.sv
module attr_reg_file #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    parameter int PAL_N  = 16,
    localparam int N_REGS = PAL_N + 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     legacy_mode,
    input  logic                     data_load,
    input  logic [IDX_W-1:0]         sel_idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [N_REGS*DATA_W-1:0] reg_flat
);
    localparam int MODE_IX  = PAL_N;
    localparam int OVSC_IX  = PAL_N + 1;
    localparam int PLANE_IX = PAL_N + 2;
    localparam int PAN_IX   = PAL_N + 3;
    localparam int CSEL_IX  = PAL_N + 4;

    // zero mask marks an index that does not exist in this mode
    function automatic logic [DATA_W-1:0] field_mask(input int ix, input logic leg);
        logic [DATA_W-1:0] m;
        m = '0;
        if (ix < PAL_N)          m = DATA_W'('h3F);
        else if (ix == MODE_IX)  m = leg ? DATA_W'('h1F) : DATA_W'('hFF);
        else if (ix == OVSC_IX)  m = leg ? DATA_W'('h3F) : DATA_W'('hFF);
        else if (ix == PLANE_IX) m = leg ? DATA_W'('h3F) : DATA_W'('h0F);
        else if (ix == PAN_IX)   m = DATA_W'('h0F);
        else if (ix == CSEL_IX)  m = leg ? '0 : DATA_W'('h0F);
        return m;
    endfunction

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] m;
        always_comb m = field_mask(g, legacy_mode);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (data_load && sel_idx == IDX_W'(g) && m != '0)
                q <= wdata & m;
        end
        assign reg_flat[g*DATA_W +: DATA_W] = q;
    end
endmodule

// File: rtl/attr_read_mux.sv
module attr_read_mux
    import attr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    parameter int N_REGS = 21
) (
    input  logic                     legacy_mode,
    input  logic                     addr_lo,
    input  phase_t                   phase,
    input  logic [IDX_W-1:0]         idx,
    input  logic [N_REGS*DATA_W-1:0] reg_flat,
    output logic [DATA_W-1:0]        rd_word
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int k = 0; k < N_REGS; k++) begin
            if (idx == IDX_W'(k)) sel = reg_flat[k*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        if (legacy_mode)  rd_word = '0;
        else if (addr_lo) rd_word = sel;
        else              rd_word = {phase == PH_DATA, {(DATA_W-1-IDX_W){1'b0}}, idx};
    end
endmodule

// File: rtl/attr_port_top.sv
module attr_port_top
    import attr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int PAL_N  = DEF_PAL_N,
    localparam int N_REGS = PAL_N + 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    legacy_mode,
    input  logic                    addr_lo,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    ff_clear,
    output logic [DATA_W-1:0]       rdata,
    output logic [PAL_N*DATA_W-1:0] palette_flat,
    output logic [DATA_W-1:0]       mode_ctrl,
    output logic [DATA_W-1:0]       overscan,
    output logic [DATA_W-1:0]       plane_enable,
    output logic [DATA_W-1:0]       pixel_pan,
    output logic [DATA_W-1:0]       color_sel
);
    phase_t                   phase;
    logic                     phase_is_data;
    logic                     port_wr;
    logic                     idx_load;
    logic                     data_load;
    logic [IDX_W-1:0]         idx_q;
    logic [N_REGS*DATA_W-1:0] reg_flat;
    logic [DATA_W-1:0]        rd_word;

    // companion address aliases the main port only in legacy mode
    assign port_wr       = wr_en && (!addr_lo || legacy_mode);
    assign phase_is_data = (phase == PH_DATA);

    attr_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_wr   (port_wr),
        .ff_clear  (ff_clear),
        .phase     (phase),
        .idx_load  (idx_load),
        .data_load (data_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (idx_load) idx_q <= wdata[IDX_W-1:0];
    end

    attr_reg_file #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PAL_N(PAL_N)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .legacy_mode (legacy_mode),
        .data_load   (data_load),
        .sel_idx     (idx_q),
        .wdata       (wdata),
        .reg_flat    (reg_flat)
    );

    attr_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_REGS(N_REGS)) u_rd (
        .legacy_mode (legacy_mode),
        .addr_lo     (addr_lo),
        .phase       (phase),
        .idx         (idx_q),
        .reg_flat    (reg_flat),
        .rd_word     (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    assign palette_flat = reg_flat[PAL_N*DATA_W-1:0];
    assign mode_ctrl    = reg_flat[(PAL_N+0)*DATA_W +: DATA_W];
    assign overscan     = reg_flat[(PAL_N+1)*DATA_W +: DATA_W];
    assign plane_enable = reg_flat[(PAL_N+2)*DATA_W +: DATA_W];
    assign pixel_pan    = reg_flat[(PAL_N+3)*DATA_W +: DATA_W];
    assign color_sel    = reg_flat[(PAL_N+4)*DATA_W +: DATA_W];
endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    parameter int PAL_N  = 16,
    localparam int N_REGS = PAL_N + 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     legacy_mode,
    input logic                     addr_lo,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic                     ff_clear,
    input logic                     phase_data,
    input logic [IDX_W-1:0]         cur_idx,
    input logic [N_REGS*DATA_W-1:0] regs_flat,
    input logic [DATA_W-1:0]        ovsc
);
    logic pw;
    assign pw = wr_en && (!addr_lo || legacy_mode) && !ff_clear;

    assert_clear_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clear |=> !phase_data);

    assert_index_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pw && !phase_data) |=> phase_data && $stable(regs_flat));

    assert_data_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pw && phase_data) |=> !phase_data);

    assert_legacy_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_mode && addr_lo && wr_en && !ff_clear) |=> phase_data != $past(phase_data));

    assert_ext_companion_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_mode && addr_lo && wr_en && !ff_clear)
        |=> $stable(phase_data) && $stable(regs_flat) && $stable(cur_idx));

    assert_ovsc_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_mode && pw && phase_data && cur_idx == IDX_W'(PAL_N + 1))
        |=> ovsc[DATA_W-1:6] == '0);

    assert_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pw && phase_data && cur_idx >= IDX_W'(N_REGS)) |=> $stable(regs_flat) && !phase_data);

    assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !ff_clear) |=> $stable(phase_data) && $stable(regs_flat));
endmodule

bind attr_port_top attr_port_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PAL_N(PAL_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .addr_lo     (addr_lo),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .ff_clear    (ff_clear),
    .phase_data  (phase_is_data),
    .cur_idx     (idx_q),
    .regs_flat   (reg_flat),
    .ovsc        (overscan)
);

// File: tb/sim_attr_port_top.sv
module sim_attr_port_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         legacy_mode = 1'b0;
    logic         addr_lo = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   wdata = 8'h00;
    logic         ff_clear = 1'b0;
    logic [7:0]   rdata;
    logic [127:0] palette_flat;
    logic [7:0]   mode_ctrl, overscan, plane_enable, pixel_pan, color_sel;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    attr_port_top u0 (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .addr_lo(addr_lo),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .ff_clear(ff_clear),
        .rdata(rdata), .palette_flat(palette_flat), .mode_ctrl(mode_ctrl),
        .overscan(overscan), .plane_enable(plane_enable), .pixel_pan(pixel_pan),
        .color_sel(color_sel)
    );

    // behavioural reference
    int m_ph, m_idx, m_rd;
    int m_reg[0:20];

    function automatic int bmask(int ix, bit leg);
        if (ix < 16)  return 'h3F;
        if (ix == 16) return leg ? 'h1F : 'hFF;
        if (ix == 17) return leg ? 'h3F : 'hFF;
        if (ix == 18) return leg ? 'h3F : 'h0F;
        if (ix == 19) return 'h0F;
        if (ix == 20) return leg ? 0 : 'h0F;
        return 0;
    endfunction

    always @(posedge clk) begin : model
        bit pw;
        int mk;
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_rd = 0;
            for (int i = 0; i < 21; i++) m_reg[i] = 0;
        end else begin
            pw = wr_en && (!addr_lo || legacy_mode);
            if (rd_en) begin
                if (legacy_mode)  m_rd = 0;
                else if (addr_lo) m_rd = (m_idx < 21) ? m_reg[m_idx] : 0;
                else              m_rd = (m_ph << 7) | m_idx;
            end
            if (ff_clear) m_ph = 0;
            else if (pw) begin
                if (m_ph == 0) begin
                    m_idx = wdata & 'h1F; m_ph = 1;
                end else begin
                    mk = bmask(m_idx, legacy_mode);
                    if (mk != 0) m_reg[m_idx] = wdata & mk;
                    m_ph = 0;
                end
            end
        end
    end

    task automatic expect8(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        int bad;
        int a, e;
        bad = 0; a = 0; e = 0;
        checks++;
        for (int i = 0; i < 16; i++)
            if (bad == 0 && int'(palette_flat[8*i +: 8]) != m_reg[i]) begin
                bad = 1; a = palette_flat[8*i +: 8]; e = m_reg[i];
            end
        if (bad == 0 && int'(mode_ctrl) != m_reg[16])    begin bad = 1; a = mode_ctrl;    e = m_reg[16]; end
        if (bad == 0 && int'(overscan) != m_reg[17])     begin bad = 1; a = overscan;     e = m_reg[17]; end
        if (bad == 0 && int'(plane_enable) != m_reg[18]) begin bad = 1; a = plane_enable; e = m_reg[18]; end
        if (bad == 0 && int'(pixel_pan) != m_reg[19])    begin bad = 1; a = pixel_pan;    e = m_reg[19]; end
        if (bad == 0 && int'(color_sel) != m_reg[20])    begin bad = 1; a = color_sel;    e = m_reg[20]; end
        if (bad == 0 && int'(rdata) != m_rd)             begin bad = 1; a = rdata;        e = m_rd;      end
        if (bad != 0) begin
            failures++;
            $display("FAIL %s model compare actual=%02h expected=%02h", cur_req, a, e);
        end
    endtask

    // one clock: compare at the falling edge, then drive the next inputs
    task automatic drive(bit w, bit r, bit a, int d, bit c);
        @(negedge clk);
        if (rst_n) compare_model();
        wr_en = w; rd_en = r; addr_lo = a; wdata = d[7:0]; ff_clear = c;
    endtask
    task automatic wr(bit a, int d);  drive(1, 0, a, d, 0); endtask
    task automatic rd(bit a);         drive(0, 1, a, 0, 0); endtask
    task automatic idle();            drive(0, 0, 0, 0, 0); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        expect8("R1", "rdata", rdata, 0);
        expect8("R1", "overscan", overscan, 0);
        expect8("R1", "palette0", palette_flat[7:0], 0);
        rst_n = 1'b1;
        rd(0); idle();
        expect8("R1", "main read after reset", rdata, 8'h00);

        // extended mode: R2, R4, R5, R8
        cur_req = "R2";
        legacy_mode = 0;
        wr(0, 8'h03); wr(0, 8'hAB); idle();
        expect8("R2", "palette3", palette_flat[31:24], 8'h2B);
        cur_req = "R4";
        rd(1); idle();
        expect8("R4", "companion read", rdata, 8'h2B);
        cur_req = "R5";
        rd(0); idle();
        expect8("R5", "main read index phase", rdata, 8'h03);
        wr(0, 8'h11); rd(0); idle();
        expect8("R5", "main read data phase", rdata, 8'h91);
        cur_req = "R8";
        wr(0, 8'hFF); wr(0, 8'h12); wr(0, 8'hFF); wr(0, 8'h10); wr(0, 8'hFF); idle();
        expect8("R8", "overscan ext", overscan, 8'hFF);
        expect8("R8", "plane ext", plane_enable, 8'h0F);
        expect8("R8", "mode ext", mode_ctrl, 8'hFF);
        cur_req = "R4";
        wr(1, 8'h13); rd(0); idle();
        expect8("R4", "ext companion write ignored", rdata, 8'h10);

        // legacy mode: R3, R8, R5, R9
        cur_req = "R3";
        legacy_mode = 1;
        wr(1, 8'h11); wr(0, 8'hFF); idle();
        expect8("R3", "companion index write", overscan, 8'h3F);
        wr(0, 8'h10); wr(1, 8'hFF); idle();
        expect8("R8", "mode legacy", mode_ctrl, 8'h1F);
        wr(1, 8'h12); wr(1, 8'hFF); idle();
        expect8("R8", "plane legacy", plane_enable, 8'h3F);
        cur_req = "R5";
        rd(1); idle();
        expect8("R5", "legacy read zero", rdata, 8'h00);
        cur_req = "R9";
        wr(0, 8'h14); wr(0, 8'h0C); wr(0, 8'h13); wr(0, 8'h07); idle();
        expect8("R9", "csel absent in legacy", color_sel, 8'h00);
        expect8("R9", "phase toggled after undefined", pixel_pan, 8'h07);

        // R6 clear strobe
        cur_req = "R6";
        wr(0, 8'h05); drive(0, 0, 0, 0, 1); wr(0, 8'h06); wr(0, 8'h21); idle();
        expect8("R6", "palette6", palette_flat[55:48], 8'h21);
        expect8("R6", "palette5 untouched", palette_flat[47:40], 8'h00);
        wr(0, 8'h08); drive(1, 0, 0, 8'h3C, 1); wr(0, 8'h09); wr(0, 8'h11); idle();
        expect8("R6", "palette9", palette_flat[79:72], 8'h11);
        expect8("R6", "palette8 discarded", palette_flat[71:64], 8'h00);

        // R7 back-to-back halves of a 16-bit write
        cur_req = "R7";
        legacy_mode = 0;
        wr(0, 8'h0A); wr(0, 8'h15); wr(0, 8'h0B); wr(0, 8'h2A); idle();
        expect8("R7", "palette10", palette_flat[87:80], 8'h15);
        expect8("R7", "palette11", palette_flat[95:88], 8'h2A);

        // R9 undefined index in extended mode
        cur_req = "R9";
        wr(0, 8'h1A); wr(0, 8'h77); rd(1); idle();
        expect8("R9", "undefined read", rdata, 8'h00);
        wr(0, 8'h14); wr(0, 8'hFF); rd(0); idle();
        expect8("R9", "csel ext", color_sel, 8'h0F);
        expect8("R9", "phase back to index", rdata, 8'h14);

        // R10 reads are side-effect free
        cur_req = "R10";
        wr(0, 8'h02); rd(1); rd(1); rd(0); idle();
        expect8("R10", "phase kept data", rdata, 8'h82);
        wr(0, 8'h09); idle();
        expect8("R10", "palette2 after reads", palette_flat[23:16], 8'h09);

        // mixed traffic against the model
        cur_req = "R2";
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) legacy_mode = lfsr[4];
            drive(lfsr[5] | lfsr[6], lfsr[7], lfsr[8], {3'b000, lfsr[13:9]} ^ {lfsr[2:0], 5'b0},
                  lfsr[15:11] == 5'h1F);
        end
        idle(); idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule